// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, given as a segment number plus an offset, into a physical address. It holds a small on-chip table of segment descriptors. Each descriptor carries a base address, a length, three permission bits (read, write, execute) and a present flag. One access request can arrive every cycle, tagged with its kind. One cycle later the block returns either the translated address or a fault code. The code tells software why the access was refused, so that it can bring an absent segment into memory or stop an illegal reference.

The table is loaded through a separate write port, one descriptor per cycle. Each access passes through three checks in a fixed order: presence, then range, then permission. Only the first check that fails is reported. The physical address is the base plus the offset, wrapped to the physical address width.

The block has no state machine. The datapath is a descriptor register file, a combinational check stage and one result register.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst_n` is low, `rsp_valid` is 0. Reset clears every descriptor to not present, so any request made after reset and before a write reports code 1.
- R2: A request with `req_valid` high at a clock edge produces `rsp_valid` = 1 at the next edge. When no check fails, `rsp_fault` = 0, `rsp_code` = 0 and `rsp_paddr` = (base + offset) modulo 2^PA_W.
- R3: A request to a descriptor whose present flag is 0, or to a segment number at or above NUM_SEGS, reports `rsp_fault` = 1 with `rsp_code` = 1 (absent).
- R4: An offset is in range only when it is strictly below the length, compared unsigned. Otherwise the request reports `rsp_code` = 2 (range). A length of 1 admits offset 0 only, and a length of 0 admits no offset.
- R5: `req_kind` 0 (read) needs permission bit 0, kind 1 (write) needs bit 1, and kind 2 (execute) needs bit 2. Kind 3 is never permitted. A request without the needed bit reports `rsp_code` = 3 (access).
- R6: When several checks fail, only the highest-priority fault is reported: absent (1) before range (2) before access (3).
- R7: A descriptor write performed at a clock edge is not seen by a request sampled at that same edge. It is seen by requests from the next edge on.
- R8: When `req_valid` is low at an edge, the next cycle shows `rsp_valid`, `rsp_fault`, `rsp_code` and `rsp_paddr` all at 0. A faulting response drives `rsp_paddr` to 0.
- R9: A descriptor write to a segment number at or above NUM_SEGS changes nothing. Such segments stay absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_seg | input | SEG_W | Segment number of the access |
| req_ofs | input | OFS_W | Offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | SEG_W | Descriptor slot to write |
| wr_base | input | PA_W | Segment base address |
| wr_len | input | OFS_W+1 | Segment length in bytes |
| wr_perm | input | 3 | Bit 0 read, bit 1 write, bit 2 execute |
| wr_present | input | 1 | Segment present flag |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access refused |
| rsp_code | output | 2 | 0 none, 1 absent, 2 range, 3 access |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |

## Verification
The hardest case to produce from the ports is a descriptor write and a request to the same slot in the same cycle. The ordering rule only shows when the two land on one edge. The bench drives both at one falling edge and expects the old descriptor's answer. It then repeats the request on the very next cycle and expects the new one. Priority is reached with descriptors built to fail several checks at once: an absent segment with an offset past its length and a forbidden kind, and a present one with both a range and an access violation.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_RANGE  = 2'd2,
        FLT_ACCESS = 2'd3
    } flt_code_e;

    localparam int PERM_BITS = 3;
    localparam int PERM_RD   = 0;
    localparam int PERM_WR   = 1;
    localparam int PERM_EX   = 2;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int SEG_W    = 3,
    parameter int NUM_SEGS = 6,
    parameter int PA_W     = 24,
    parameter int LEN_W    = 17
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SEG_W-1:0]                   wr_seg,
    input  logic [PA_W-1:0]                    wr_base,
    input  logic [LEN_W-1:0]                   wr_len,
    input  logic [seg_xlate_pkg::PERM_BITS-1:0] wr_perm,
    input  logic                               wr_present,
    input  logic [SEG_W-1:0]                   rd_seg,
    output logic [PA_W-1:0]                    rd_base,
    output logic [LEN_W-1:0]                   rd_len,
    output logic [seg_xlate_pkg::PERM_BITS-1:0] rd_perm,
    output logic                               rd_present
);
    import seg_xlate_pkg::*;

    logic [PA_W-1:0]      base_q [NUM_SEGS];
    logic [LEN_W-1:0]     len_q  [NUM_SEGS];
    logic [PERM_BITS-1:0] perm_q [NUM_SEGS];
    logic [NUM_SEGS-1:0]  pres_q;

    // One register slot per segment; a write to a slot number with no
    // slot matches nothing and is dropped.
    for (genvar i = 0; i < NUM_SEGS; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_seg == SEG_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                len_q[i]  <= '0;
                perm_q[i] <= '0;
                pres_q[i] <= 1'b0;
            end else if (hit) begin
                base_q[i] <= wr_base;
                len_q[i]  <= wr_len;
                perm_q[i] <= wr_perm;
                pres_q[i] <= wr_present;
            end
        end
    end

    // Read mux; an index past the table yields an absent descriptor.
    always_comb begin
        rd_base    = '0;
        rd_len     = '0;
        rd_perm    = '0;
        rd_present = 1'b0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (rd_seg == SEG_W'(i)) begin
                rd_base    = base_q[i];
                rd_len     = len_q[i];
                rd_perm    = perm_q[i];
                rd_present = pres_q[i];
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int OFS_W = 16,
    parameter int PA_W  = 24,
    parameter int LEN_W = 17
) (
    input  logic                                present,
    input  logic [PA_W-1:0]                     base,
    input  logic [LEN_W-1:0]                    len,
    input  logic [seg_xlate_pkg::PERM_BITS-1:0] perm,
    input  logic [OFS_W-1:0]                    ofs,
    input  logic [1:0]                          kind,
    output logic                                fault,
    output logic [1:0]                          code,
    output logic [PA_W-1:0]                     paddr
);
    import seg_xlate_pkg::*;

    logic in_range;
    logic allowed;
    flt_code_e sel;

    assign in_range = LEN_W'(ofs) < len;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_READ:  allowed = perm[PERM_RD];
            ACC_WRITE: allowed = perm[PERM_WR];
            ACC_EXEC:  allowed = perm[PERM_EX];
            ACC_RSVD:  allowed = 1'b0;
            default:   allowed = 1'b0;
        endcase
    end

    // Priority chain: absent, then range, then access.
    always_comb begin
        if (!present)       sel = FLT_ABSENT;
        else if (!in_range) sel = FLT_RANGE;
        else if (!allowed)  sel = FLT_ACCESS;
        else                sel = FLT_NONE;
    end

    assign fault = (sel != FLT_NONE);
    assign code  = sel;
    assign paddr = fault ? '0 : (base + PA_W'(ofs));

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg #(
    parameter int PA_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_fault,
    input  logic [1:0]      in_code,
    input  logic [PA_W-1:0] in_paddr,
    output logic            out_valid,
    output logic            out_fault,
    output logic [1:0]      out_code,
    output logic [PA_W-1:0] out_paddr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_code  <= '0;
            out_paddr <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid & in_fault;
            out_code  <= in_valid ? in_code  : '0;
            out_paddr <= in_valid ? in_paddr : '0;
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
    parameter int SEG_W    = 3,
    parameter int NUM_SEGS = 6,
    parameter int OFS_W    = 16,
    parameter int PA_W     = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [SEG_W-1:0]   req_seg,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic [1:0]         req_kind,
    input  logic               wr_en,
    input  logic [SEG_W-1:0]   wr_seg,
    input  logic [PA_W-1:0]    wr_base,
    input  logic [OFS_W:0]     wr_len,
    input  logic [2:0]         wr_perm,
    input  logic               wr_present,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_code,
    output logic [PA_W-1:0]    rsp_paddr
);
    import seg_xlate_pkg::*;

    localparam int LEN_W = OFS_W + 1;

    initial begin
        if (NUM_SEGS > (1 << SEG_W) || PA_W < OFS_W)
            $error("seg_xlate_unit: parameter set out of range");
    end

    logic [PA_W-1:0]      d_base;
    logic [LEN_W-1:0]     d_len;
    logic [PERM_BITS-1:0] d_perm;
    logic                 d_present;
    logic                 c_fault;
    logic [1:0]           c_code;
    logic [PA_W-1:0]      c_paddr;

    seg_desc_table #(
        .SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .PA_W(PA_W), .LEN_W(LEN_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_seg     (wr_seg),
        .wr_base    (wr_base),
        .wr_len     (wr_len),
        .wr_perm    (wr_perm),
        .wr_present (wr_present),
        .rd_seg     (req_seg),
        .rd_base    (d_base),
        .rd_len     (d_len),
        .rd_perm    (d_perm),
        .rd_present (d_present)
    );

    seg_check #(
        .OFS_W(OFS_W), .PA_W(PA_W), .LEN_W(LEN_W)
    ) u_check (
        .present (d_present),
        .base    (d_base),
        .len     (d_len),
        .perm    (d_perm),
        .ofs     (req_ofs),
        .kind    (req_kind),
        .fault   (c_fault),
        .code    (c_code),
        .paddr   (c_paddr)
    );

    seg_resp_reg #(
        .PA_W(PA_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_fault  (c_fault),
        .in_code   (c_code),
        .in_paddr  (c_paddr),
        .out_valid (rsp_valid),
        .out_fault (rsp_fault),
        .out_code  (rsp_code),
        .out_paddr (rsp_paddr)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W    = 3,
    parameter int NUM_SEGS = 6,
    parameter int PA_W     = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_code,
    input logic [PA_W-1:0]  rsp_paddr
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_clean_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_code == 2'd0));

    p_no_table_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (32'(req_seg) >= NUM_SEGS)) |=> (rsp_fault && rsp_code == 2'd1));

    p_reserved_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> rsp_fault);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_code == 2'd0));

    p_fault_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && rsp_code != 2'd0));

endmodule

bind seg_xlate_unit seg_xlate_chk #(
    .SEG_W(SEG_W), .NUM_SEGS(NUM_SEGS), .PA_W(PA_W)
) u_chk (.*);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;

    localparam int SEG_W = 3;
    localparam int NSEG  = 6;
    localparam int OFS_W = 16;
    localparam int PA_W  = 24;
    localparam int VW    = SEG_W + OFS_W + 2 + 2 + PA_W;
    localparam int NV    = 17;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFS_W-1:0] req_ofs = '0;
    logic [1:0]       req_kind = '0;
    logic             wr_en = 1'b0;
    logic [SEG_W-1:0] wr_seg = '0;
    logic [PA_W-1:0]  wr_base = '0;
    logic [OFS_W:0]   wr_len = '0;
    logic [2:0]       wr_perm = '0;
    logic             wr_present = 1'b0;
    logic             rsp_valid;
    logic             rsp_fault;
    logic [1:0]       rsp_code;
    logic [PA_W-1:0]  rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .NUM_SEGS(NSEG), .OFS_W(OFS_W), .PA_W(PA_W)) u0 (.*);

    // {seg, ofs, kind, expected code, expected address}
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd0, 16'h0000, 2'd0, 2'd0, 24'h001000},
        {3'd0, 16'h00FF, 2'd1, 2'd0, 24'h0010FF},
        {3'd0, 16'h0100, 2'd0, 2'd2, 24'h000000},
        {3'd0, 16'h0010, 2'd2, 2'd3, 24'h000000},
        {3'd1, 16'h0000, 2'd2, 2'd0, 24'h020000},
        {3'd1, 16'h0001, 2'd2, 2'd2, 24'h000000},
        {3'd1, 16'h0000, 2'd0, 2'd3, 24'h000000},
        {3'd2, 16'h0200, 2'd1, 2'd0, 24'h000100},
        {3'd2, 16'hFFFF, 2'd2, 2'd0, 24'h00FEFF},
        {3'd3, 16'h0000, 2'd0, 2'd1, 24'h000000},
        {3'd3, 16'h0040, 2'd1, 2'd1, 24'h000000},
        {3'd4, 16'h0000, 2'd0, 2'd2, 24'h000000},
        {3'd5, 16'h0000, 2'd0, 2'd1, 24'h000000},
        {3'd6, 16'h0000, 2'd0, 2'd1, 24'h000000},
        {3'd7, 16'h0000, 2'd0, 2'd1, 24'h000000},
        {3'd0, 16'h0200, 2'd2, 2'd2, 24'h000000},
        {3'd0, 16'h0004, 2'd3, 2'd3, 24'h000000}
    };

    task automatic check(input string req, input logic v, input logic [1:0] code,
                         input logic [PA_W-1:0] pa);
        logic ef;
        ef = (code != 2'd0);
        checks++;
        if (rsp_valid !== v || rsp_fault !== ef || rsp_code !== code || rsp_paddr !== pa) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0b code=%0d pa=%h, expected v=%0b f=%0b code=%0d pa=%h",
                     req, rsp_valid, rsp_fault, rsp_code, rsp_paddr, v, ef, code, pa);
        end
    endtask

    task automatic wr_desc(input logic [SEG_W-1:0] s, input logic [PA_W-1:0] b,
                           input logic [OFS_W:0] l, input logic [2:0] p, input logic pr);
        @(negedge clk);
        wr_en = 1'b1; wr_seg = s; wr_base = b; wr_len = l; wr_perm = p; wr_present = pr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic [SEG_W-1:0] s, input logic [OFS_W-1:0] o,
                         input logic [1:0] k);
        req_valid = 1'b1; req_seg = s; req_ofs = o; req_kind = k;
    endtask

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'd0: return "R2 translate";
            2'd1: return "R3 absent";
            2'd2: return "R4 range";
            default: return "R5 access";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: quiet during reset
        repeat (3) @(negedge clk);
        check("R1 reset valid", 1'b0, 2'd0, '0);
        rst_n = 1'b1;
        // R1: cleared table reports absent
        @(negedge clk); issue(3'd0, 16'h0, 2'd0);
        @(negedge clk); req_valid = 1'b0;
        check("R1 cleared table", 1'b1, 2'd1, '0);

        // perm: bit0 read, bit1 write, bit2 exec
        wr_desc(3'd0, 24'h001000, 17'h00100, 3'b011, 1'b1);
        wr_desc(3'd1, 24'h020000, 17'h00001, 3'b100, 1'b1);
        wr_desc(3'd2, 24'hFFFF00, 17'h10000, 3'b111, 1'b1);
        wr_desc(3'd3, 24'h005000, 17'h00020, 3'b001, 1'b0);
        wr_desc(3'd4, 24'h007000, 17'h00000, 3'b111, 1'b1);
        // R9: writes past the table are dropped
        wr_desc(3'd6, 24'h00A000, 17'h00100, 3'b111, 1'b1);
        wr_desc(3'd7, 24'h00B000, 17'h00100, 3'b111, 1'b1);

        // Vector walk; R6 priority cases are entries 11 and 16
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            @(negedge clk);
            issue(v[VW-1 -: SEG_W], v[VW-SEG_W-1 -: OFS_W], v[PA_W+3 -: 2]);
            @(negedge clk);
            req_valid = 1'b0;
            if (i == 10 || i == 15)
                check("R6 priority", 1'b1, v[PA_W+1 -: 2], v[PA_W-1:0]);
            else if (i == 13 || i == 14)
                check("R9 dropped write", 1'b1, v[PA_W+1 -: 2], v[PA_W-1:0]);
            else
                check(tag_of(v[PA_W+1 -: 2]), 1'b1, v[PA_W+1 -: 2], v[PA_W-1:0]);
        end

        // R8: idle cycle is quiet
        @(negedge clk);
        check("R8 idle", 1'b0, 2'd0, '0);

        // R7: write and request to slot 5 on one edge, then request again
        @(negedge clk);
        wr_en = 1'b1; wr_seg = 3'd5; wr_base = 24'h009000; wr_len = 17'h00010;
        wr_perm = 3'b001; wr_present = 1'b1;
        issue(3'd5, 16'h0002, 2'd0);
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 same-edge old", 1'b1, 2'd1, '0);
        issue(3'd5, 16'h0002, 2'd0);
        @(negedge clk);
        check("R7 next-edge new", 1'b1, 2'd0, 24'h009002);
        // back-to-back: R4 boundary on the new slot at offset == length
        issue(3'd5, 16'h0010, 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 offset equals length", 1'b1, 2'd2, '0);
        @(negedge clk);
        check("R8 idle after burst", 1'b0, 2'd0, '0);

        // R1: reset mid-run clears descriptors
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", 1'b0, 2'd0, '0);
        rst_n = 1'b1;
        @(negedge clk); issue(3'd0, 16'h0, 2'd0);
        @(negedge clk); req_valid = 1'b0;
        check("R1 table cleared again", 1'b1, 2'd1, '0);

        finish_run();
    end

endmodule